// File: doc/BRIEF.md
# Strobe-Clocked Serial ROM Stream Transmitter

This block sends the lower half of a 256-byte array as an endless serial bitstream on one open-drain data line. A slow external strobe, which is asynchronous to the system clock, paces the stream. The strobe is brought into the system-clock domain through a synchronizer, and each rising edge of the strobe moves the stream forward by one bit slot.

After reset the line stays released for a fixed number of strobe rising edges while the block synchronizes. After that it drives each byte most significant bit first. Each byte is followed by a null slot in which the line is released. The byte address counts up through the first 128 locations and then returns to zero. The array is read through a combinational read port. The byte at `rd_addr` must be present on `rd_data` in the same cycle.

A mode controller gates the block through `enable`. Dropping `enable` releases the line and returns the stream position to byte zero, bit seven. When `enable` comes back after synchronization has already finished, the next strobe rising edge drives the MSB of address 00h at once. When `enable` comes back before synchronization has finished, the synchronization count starts again from zero.

Top module: `romstream_tx`

## Requirements
- R1: While reset is asserted and directly after it, `sda_oe` is 0 and `sda_out` is 1.
- R2: With `enable` high after reset, the line stays released (`sda_oe`=0) for the first nine strobe rising edges.
- R3: The tenth strobe rising edge after reset drives bit 7 of the byte at address 00h, with `rd_addr`=00h and `sda_oe`=1.
- R4: Each strobe rising edge advances exactly one bit slot. Slots 0 to 7 carry data bits 7 down to 0 on `sda_out` with `sda_oe`=1. A strobe falling edge changes nothing.
- R5: Slot 8 of every byte is a null slot, with `sda_oe`=0 and `sda_out`=1.
- R6: After each null slot the read address increases by one. `rd_addr` bit 7 is always 0.
- R7: After the null slot of address 7Fh, the next bit is bit 7 of address 00h.
- R8: One cycle after `enable` is low, `sda_oe` is 0 and `rd_addr` is 00h, and strobe edges have no effect. If a strobe rising edge and a low `enable` fall in the same cycle, the disable wins.
- R9: When `enable` returns after synchronization has completed, the line stays released until the next strobe rising edge. That edge drives bit 7 of address 00h, and the following edge drives bit 6.
- R10: A disable during synchronization clears the synchronization count. After re-enable, nine further rising edges leave the line released and the tenth drives bit 7 of address 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Stream enable from the mode controller |
| strobe_in | input | 1 | Asynchronous stream strobe |
| rd_data | input | 8 | Byte returned by the array for `rd_addr` |
| rd_addr | output | 8 | Array read address (lower half only) |
| sda_out | output | 1 | Data value for the line |
| sda_oe | output | 1 | Drive enable for the line (0 = released) |

## Verification
The detected strobe rising edge and the disable from the mode controller can land on the same clock edge. If that happened, the stream would advance and be cleared at the same moment. The bench provokes this by raising the strobe and then holding `enable` low for exactly one cycle: the cycle in which the synchronized edge pulse is present. It then checks that the line stays released and `rd_addr` is 00h after `enable` returns. A design that let the edge win would leave the stream mid-byte and driving. The next strobe must then produce bit 7 of address 00h.

// File: rtl/romstream_pkg.sv
package romstream_pkg;

    localparam int BYTE_W = 8;
    localparam int SLOT_W = $clog2(BYTE_W + 1);
    localparam int BIT_IW = $clog2(BYTE_W);
    localparam logic [SLOT_W-1:0] NULL_SLOT = SLOT_W'(BYTE_W);

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_ARMED = 2'd1,
        PH_SEND  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [SLOT_W-1:0]   slot;
    } slot_state_t;

    // Data bit carried by a slot; the null slot reads as released (1).
    function automatic logic slot_bit(input logic [BYTE_W-1:0] b,
                                      input logic [SLOT_W-1:0] slot);
        logic [BIT_IW-1:0] idx;
        idx = BIT_IW'(BYTE_W - 1) - slot[BIT_IW-1:0];
        if (slot >= NULL_SLOT) return 1'b1;
        return b[idx];
    endfunction

endpackage

// File: rtl/romstream_strobe_sync.sv
module romstream_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic rise
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], strobe_async};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // One slot per strobe edge: a detected edge lasts a single cycle
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/romstream_seq.sv
module romstream_seq
    import romstream_pkg::*;
#(
    parameter int STREAM_DEPTH = 128,
    parameter int STREAM_AW    = 7,
    parameter int SYNC_PULSES  = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  rise,
    output phase_e                phase_o,
    output logic [SLOT_W-1:0]     slot_o,
    output logic [STREAM_AW-1:0]  addr_o
);
    localparam int SC_W = $clog2(SYNC_PULSES + 1);
    localparam logic [SC_W-1:0]      SYNC_LAST = SC_W'(SYNC_PULSES);
    localparam logic [STREAM_AW-1:0] ADDR_LAST = STREAM_AW'(STREAM_DEPTH - 1);

    slot_state_t          st_q, st_d;
    logic [SC_W-1:0]      cnt_q, cnt_d;
    logic [STREAM_AW-1:0] addr_q, addr_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        addr_d = addr_q;
        if (!enable) begin
            // disable outranks a coincident strobe edge
            st_d.slot = '0;
            addr_d    = '0;
            if (st_q.phase == PH_SYNC) cnt_d = '0;
            else                       st_d.phase = PH_ARMED;
        end else if (rise) begin
            unique case (st_q.phase)
                PH_SYNC: begin
                    if (cnt_q == SYNC_LAST) st_d.phase = PH_SEND;
                    else                    cnt_d = cnt_q + 1'b1;
                end
                PH_ARMED: st_d.phase = PH_SEND;
                PH_SEND: begin
                    if (st_q.slot == NULL_SLOT) begin
                        st_d.slot = '0;
                        addr_d    = (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
                    end else begin
                        st_d.slot = st_q.slot + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{phase: PH_SYNC, slot: '0};
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            addr_q <= addr_d;
        end
    end

    assign phase_o = st_q.phase;
    assign slot_o  = st_q.slot;
    assign addr_o  = addr_q;

    assert_first_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && rise && st_q.phase == PH_SYNC && cnt_q == SYNC_LAST)
        |=> (st_q.phase == PH_SEND && st_q.slot == '0 && addr_q == '0));

    assert_slot_step_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && rise && st_q.phase == PH_SEND && st_q.slot != NULL_SLOT)
        |=> (st_q.slot == $past(st_q.slot) + 1'b1 && $stable(addr_q)));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (enable && rise && st_q.phase == PH_SEND && st_q.slot == NULL_SLOT
         && addr_q != ADDR_LAST)
        |=> (addr_q == $past(addr_q) + 1'b1 && st_q.slot == '0));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && rise && st_q.phase == PH_SEND && st_q.slot == NULL_SLOT
         && addr_q == ADDR_LAST)
        |=> (addr_q == '0));

    assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (st_q.phase != PH_SEND && addr_q == '0 && st_q.slot == '0));

endmodule

// File: rtl/romstream_drive.sv
module romstream_drive
    import romstream_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  phase_e              phase,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic                sda_out,
    output logic                sda_oe
);
    logic sending;

    always_comb begin
        sending = (phase == PH_SEND);
        sda_oe  = sending && (slot != NULL_SLOT);
        sda_out = sending ? slot_bit(rd_data, slot) : 1'b1;
    end

    assert_quiet_unless_sending_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_SEND) |-> (!sda_oe && sda_out));

    assert_null_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (slot == NULL_SLOT) |-> (!sda_oe && sda_out));

endmodule

// File: rtl/romstream_tx.sv
module romstream_tx
    import romstream_pkg::*;
#(
    parameter int ARRAY_AW     = 8,
    parameter int STREAM_DEPTH = 128,
    parameter int SYNC_PULSES  = 9,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 strobe_in,
    input  logic [BYTE_W-1:0]    rd_data,
    output logic [ARRAY_AW-1:0]  rd_addr,
    output logic                 sda_out,
    output logic                 sda_oe
);
    localparam int STREAM_AW = $clog2(STREAM_DEPTH);

    logic                 rise;
    phase_e               phase;
    logic [SLOT_W-1:0]    slot;
    logic [STREAM_AW-1:0] addr;

    romstream_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (strobe_in),
        .rise         (rise)
    );

    romstream_seq #(
        .STREAM_DEPTH (STREAM_DEPTH),
        .STREAM_AW    (STREAM_AW),
        .SYNC_PULSES  (SYNC_PULSES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .rise    (rise),
        .phase_o (phase),
        .slot_o  (slot),
        .addr_o  (addr)
    );

    generate
        if (ARRAY_AW > STREAM_AW) begin : g_zext
            assign rd_addr = {{(ARRAY_AW - STREAM_AW){1'b0}}, addr};
        end else begin : g_direct
            assign rd_addr = addr[ARRAY_AW-1:0];
        end
    endgenerate

    romstream_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .slot    (slot),
        .rd_data (rd_data),
        .sda_out (sda_out),
        .sda_oe  (sda_oe)
    );

endmodule

// File: tb/romstream_tx_bench.sv
module romstream_tx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       strobe = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] rd_addr;
    logic       sda_out, sda_oe;
    logic [7:0] mem [256];

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic hi_oe, hi_out;

    always #2 clk = ~clk;

    assign rd_data = mem[rd_addr];

    romstream_tx u_romstream_tx (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .strobe_in (strobe),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .sda_out   (sda_out),
        .sda_oe    (sda_oe)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 7) ^ (i * 8));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one strobe period; outputs recorded at end of high phase
    task automatic pulse();
        strobe = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        hi_oe  = sda_oe;
        hi_out = sda_out;
        strobe = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_slot(input int a, input int s, input string req);
        if (s < 8) begin
            check(sda_oe == 1'b1, req, "oe", int'(sda_oe), 1);
            check(sda_out == mem[a][7-s], req, "data bit", int'(sda_out), int'(mem[a][7-s]));
            check(rd_addr == 8'(a), req, "rd_addr", int'(rd_addr), a);
        end else begin
            check(sda_oe == 1'b0, "R5", "null oe", int'(sda_oe), 0);
            check(sda_out == 1'b1, "R5", "null out", int'(sda_out), 1);
        end
        check({hi_oe, hi_out} == {sda_oe, sda_out}, "R4", "falling strobe effect",
              int'({sda_oe, sda_out}), int'({hi_oe, hi_out}));
    endtask

    task automatic do_reset();
        rst = 1'b1; enable = 1'b0; strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sda_oe == 1'b0 && sda_out == 1'b1, "R1", "in reset", int'({sda_oe, sda_out}), 1);
        rst = 1'b0; enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);
        check(sda_out == 1'b1, "R1", "out after reset", int'(sda_out), 1);
    endtask

    task automatic t_sync();
        for (int i = 0; i < 9; i++) begin
            pulse();
            check(sda_oe == 1'b0, "R2", "released during sync", int'(sda_oe), 0);
        end
        pulse();
        expect_slot(0, 0, "R3");
    endtask

    task automatic t_stream();
        for (int s = 1; s <= 8; s++) begin
            pulse();
            expect_slot(0, s, "R4");
        end
        for (int a = 1; a < 128; a++) begin
            for (int s = 0; s <= 8; s++) begin
                pulse();
                expect_slot(a, s, "R6");
            end
            check(rd_addr[7] == 1'b0, "R6", "upper address bit", int'(rd_addr[7]), 0);
        end
        pulse();
        expect_slot(0, 0, "R7");
    endtask

    task automatic t_disable();
        for (int i = 0; i < 12; i++) pulse();
        expect_slot(1, 3, "R4");
        enable = 1'b0;
        repeat (2) @(negedge clk);
        check(sda_oe == 1'b0, "R8", "oe when disabled", int'(sda_oe), 0);
        check(rd_addr == 8'h00, "R8", "rd_addr when disabled", int'(rd_addr), 0);
        for (int i = 0; i < 3; i++) begin
            pulse();
            check(sda_oe == 1'b0, "R8", "strobe while disabled", int'(sda_oe), 0);
            check(rd_addr == 8'h00, "R8", "addr while disabled", int'(rd_addr), 0);
        end
        enable = 1'b1;
        @(negedge clk);
        check(sda_oe == 1'b0, "R9", "released before first edge", int'(sda_oe), 0);
        pulse();
        expect_slot(0, 0, "R9");
        pulse();
        expect_slot(0, 1, "R9");
    endtask

    task automatic t_coincide();
        for (int i = 0; i < 10; i++) pulse();
        expect_slot(1, 2, "R4");
        strobe = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        enable = 1'b0;          // low only for the edge-detect cycle
        @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        strobe = 1'b0;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R8", "coincident disable oe", int'(sda_oe), 0);
        check(rd_addr == 8'h00, "R8", "coincident disable addr", int'(rd_addr), 0);
        pulse();
        expect_slot(0, 0, "R9");
    endtask

    task automatic t_sync_abort();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            pulse();
            check(sda_oe == 1'b0, "R2", "partial sync", int'(sda_oe), 0);
        end
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            pulse();
            check(sda_oe == 1'b0, "R10", "sync restarted", int'(sda_oe), 0);
        end
        pulse();
        expect_slot(0, 0, "R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        @(negedge clk);
        t_reset();
        t_sync();
        t_stream();
        t_disable();
        t_coincide();
        t_sync_abort();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule